// File: doc/BRIEF.md
# Protected-Zone Access Ordering Guard

A pipelined CPU issues its writes late and its reads early, so a read that follows a write in program order can reach the memory bus first. For ordinary memory this is harmless. For peripheral registers, a read that depends on an earlier write returns stale state. This guard sits between the CPU's data-access stage and the bus. It holds at most one write at a time in a single pending slot, and normally lets a read go ahead of that write. It holds the read back only when it would break program order somewhere that matters.

A read is held when both of these are true:
- A write is pending, or a write arrives in the same cycle. A same-cycle write counts as the older access.
- Either the read falls inside the protected zone while protection is enabled, or the read hits the exact address of that write.

While the read is held, the bus carries the write. The read goes out in the cycle after the bus grants the write. The protected zone is one contiguous address window, bounded by an inclusive base and limit. It is sized to cover two adjacent peripheral frames. A single enable bit switches protection on and off, and it comes out of reset switched on.

Top module: `zone_order_guard`

## Requirements
- R1: After reset, bus_req, rd_stall and wr_stall are 0 and protection is enabled: a zone read that follows a pending write is held before any configuration write.
- R2: A read outside the zone, with an address different from every older write, is placed on the bus (bus_req=1, bus_we=0, bus_addr=rd_addr) in the same cycle even while a write is pending.
- R3: While a write is pending and protection is on, a read with ZONE_BASE <= rd_addr <= ZONE_LIMIT is not placed on the bus. The bus carries the pending write (bus_we=1, with its address and data) and rd_stall is 1.
- R4: A held read appears on the bus in the cycle right after the cycle in which bus_gnt accepted the blocking write.
- R5: A read whose address equals the pending write's address is held even when it is outside the zone or protection is off.
- R6: A cycle with cfg_we=1 loads cfg_prot_en into the enable bit. With it at 0, zone reads overtake pending writes like any other read.
- R7: The zone bounds are inclusive: addresses ZONE_BASE and ZONE_LIMIT are held, and ZONE_BASE-1 and ZONE_LIMIT+1 are not.
- R8: Writes reach the bus in arrival order. A write that arrives while another is pending and not granted gets wr_stall=1 and is not taken.
- R9: A write and a zone read presented in the same cycle count as write-then-read: the read is held (rd_stall=1) and the write is taken.
- R10: A request that is not granted stays on the bus unchanged. A read offered to the bus without bus_gnt keeps rd_stall=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the protection enable bit |
| cfg_prot_en | input | 1 | New value of the protection enable bit |
| wr_req | input | 1 | Write request from pipeline |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_stall | output | 1 | Write not taken this cycle |
| rd_req | input | 1 | Read request from pipeline |
| rd_addr | input | ADDR_W | Read address |
| rd_stall | output | 1 | Read not issued this cycle |
| bus_req | output | 1 | Bus request valid |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_gnt | input | 1 | Bus accepts the current request |

## Verification
The bench builds the guard with ADDR_W=8, DATA_W=8, and a zone from 0x40 to 0x7F. With this setup a quarter of random addresses land in the zone, and random reads often hit the pending write's address. This brings all four outcomes within reach under random stimulus:
- reorder,
- zone hold,
- same-address hold,
- same-cycle hold.

Directed steps cover the reset default of the enable bit, all four zone edges, toggling the enable bit, and the read issuing one cycle after the write is granted.

// File: rtl/zone_order_guard.sv
module zone_order_guard #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] ZONE_BASE = ADDR_W'(24576),
  parameter logic [ADDR_W-1:0] ZONE_LIMIT = ADDR_W'(32767)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_prot_en,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_stall,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_stall,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt
);

  logic              prot_en;
  logic              pw_valid;
  logic [ADDR_W-1:0] pw_addr;
  logic [DATA_W-1:0] pw_data;

  logic rd_in_zone, zone_block, hz_pend, hz_new, rd_go, wr_acc;

  assign rd_in_zone = (rd_addr >= ZONE_BASE) && (rd_addr <= ZONE_LIMIT);
  assign zone_block = prot_en && rd_in_zone;
  assign hz_pend    = pw_valid && (zone_block || (rd_addr == pw_addr));
  assign hz_new     = wr_req && (zone_block || (rd_addr == wr_addr));
  assign rd_go      = rd_req && !hz_pend && !hz_new;

  assign bus_req   = rd_go || pw_valid;
  assign bus_we    = !rd_go;
  assign bus_addr  = rd_go ? rd_addr : pw_addr;
  assign bus_wdata = pw_data;

  assign wr_acc   = bus_gnt && pw_valid && !rd_go;
  assign rd_stall = rd_req && !(rd_go && bus_gnt);
  assign wr_stall = wr_req && pw_valid && !wr_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_en  <= 1'b1;
      pw_valid <= 1'b0;
      pw_addr  <= '0;
      pw_data  <= '0;
    end else begin
      if (cfg_we) prot_en <= cfg_prot_en;
      if (wr_req && !wr_stall) begin
        pw_valid <= 1'b1;
        pw_addr  <= wr_addr;
        pw_data  <= wr_data;
      end else if (wr_acc) begin
        pw_valid <= 1'b0;
      end
    end
  end

  AST_ZONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && pw_valid && prot_en && rd_in_zone |-> !(bus_req && !bus_we)); // R3
  AST_SAME_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && pw_valid && (rd_addr == pw_addr) |-> !(bus_req && !bus_we)); // R5
  AST_FREE_REORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !wr_req && pw_valid && !rd_in_zone && (rd_addr != pw_addr)
      |-> bus_req && !bus_we && (bus_addr == rd_addr)); // R2
  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid && !(bus_gnt && bus_we) |=> pw_valid && $stable(pw_addr) && $stable(pw_data)); // R8
  AST_NO_GNT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !bus_gnt |-> rd_stall); // R10
  AST_NEW_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && wr_req && prot_en && rd_in_zone |-> rd_stall); // R9

endmodule

// File: tb/zone_order_guard_bench.sv
module zone_order_guard_bench;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam logic [7:0] ZB = 8'h40;
  localparam logic [7:0] ZL = 8'h7F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_prot_en = 0, wr_req = 0, rd_req = 0, bus_gnt = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_stall, rd_stall, bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;

  always #2.5 clk = ~clk;

  zone_order_guard #(.ADDR_W(AW), .DATA_W(DW), .ZONE_BASE(ZB), .ZONE_LIMIT(ZL)) u_zone_order_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_prot_en(cfg_prot_en),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_stall(wr_stall),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_stall(rd_stall),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt));

  int checks = 0, failures = 0;
  logic m_v = 0, m_p = 1;
  logic [AW-1:0] m_a = '0;
  logic [DW-1:0] m_d = '0;

  function automatic logic in_zone(logic [AW-1:0] a);
    return (a >= ZB) && (a <= ZL);
  endfunction

  function automatic logic blocks(logic [AW-1:0] ra, logic [AW-1:0] wa);
    return (ra == wa) || (m_p && in_zone(ra));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic w, logic [AW-1:0] wa, logic [DW-1:0] wd, logic r, logic [AW-1:0] ra,
                      logic g, logic cw, logic cv, string force_tag);
    logic hzp, hzn, go, e_req, e_we, e_rs, e_ws, acc;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_data;
    string tag;
    @(negedge clk);
    wr_req = w; wr_addr = wa; wr_data = wd; rd_req = r; rd_addr = ra;
    bus_gnt = g; cfg_we = cw; cfg_prot_en = cv;
    #1;
    hzp = m_v && blocks(ra, m_a);
    hzn = w && blocks(ra, wa);
    go = r && !hzp && !hzn;
    e_req = go || m_v;
    e_we = !go;
    e_addr = go ? ra : m_a;
    e_data = m_v ? m_d : bus_wdata;
    acc = g && m_v && !go;
    e_rs = r && !(go && g);
    e_ws = w && m_v && !acc;
    if (force_tag != "") tag = force_tag;
    else if (r && m_v && ra == m_a) tag = "R5";
    else if (r && hzn && !hzp) tag = "R9";
    else if (r && hzp) tag = "R3";
    else if (r && m_v && !m_p && in_zone(ra)) tag = "R6";
    else if (r && m_v) tag = "R2";
    else if (e_ws) tag = "R8";
    else tag = "R10";
    check(tag, {rd_stall, wr_stall, bus_req}, {e_rs, e_ws, e_req});
    if (e_req) check(tag, {bus_we, bus_addr}, {e_we, e_addr});
    if (e_req && e_we) check(tag, bus_wdata, e_data);
    @(posedge clk);
    if (cw) m_p = cv;
    if (w && !e_ws) begin m_v = 1; m_a = wa; m_d = wd; end
    else if (acc) m_v = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", {bus_req, rd_stall, wr_stall}, 3'b000);
    // R1: protection on after reset
    step(1, 8'h10, 8'hA5, 0, 8'h00, 0, 0, 0, "R1");
    step(0, 8'h00, 8'h00, 1, 8'h50, 0, 0, 0, "R1");
    // R4: grant write, read follows next cycle
    step(0, 8'h00, 8'h00, 1, 8'h50, 1, 0, 0, "R4");
    step(0, 8'h00, 8'h00, 1, 8'h50, 1, 0, 0, "R4");
    check("R4", {bus_req, bus_we, bus_addr}, {1'b1, 1'b0, 8'h50});
    // R7: zone edges with a pending write
    step(1, 8'h20, 8'h11, 0, 8'h00, 0, 0, 0, "R8");
    step(0, 8'h00, 8'h00, 1, ZB, 0, 0, 0, "R7");
    step(0, 8'h00, 8'h00, 1, ZL, 0, 0, 0, "R7");
    step(0, 8'h00, 8'h00, 1, ZB - 8'd1, 1, 0, 0, "R7");
    step(0, 8'h00, 8'h00, 1, ZL + 8'd1, 1, 0, 0, "R7");
    // R8: second write stalls behind ungranted first
    step(1, 8'h30, 8'h22, 0, 8'h00, 0, 0, 0, "R8");
    step(1, 8'h30, 8'h22, 0, 8'h00, 1, 0, 0, "R8");
    step(0, 8'h00, 8'h00, 0, 8'h00, 1, 0, 0, "R8");
    // R6: disable protection, zone read overtakes
    step(1, 8'h21, 8'h33, 0, 8'h00, 0, 1, 0, "R6");
    step(0, 8'h00, 8'h00, 1, 8'h60, 1, 0, 0, "R6");
    // R5: same address held with protection off
    step(0, 8'h00, 8'h00, 1, 8'h21, 0, 0, 0, "R5");
    step(0, 8'h00, 8'h00, 1, 8'h21, 1, 0, 0, "R5");
    // R9: same-cycle write and zone read, protection back on
    step(0, 8'h00, 8'h00, 0, 8'h00, 1, 1, 1, "R9");
    step(1, 8'h05, 8'h44, 1, 8'h45, 1, 0, 0, "R9");
    step(0, 8'h00, 8'h00, 0, 8'h00, 1, 0, 0, "R10");
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] ra, wa;
      logic w, r, g, cw;
      w = ($urandom % 3) == 0;
      r = ($urandom % 2) == 0;
      g = ($urandom % 3) != 0;
      cw = ($urandom % 50) == 0;
      wa = 8'($urandom);
      ra = (($urandom % 4) == 0 && m_v) ? m_a : 8'($urandom);
      step(w, wa, 8'($urandom), r, ra, g, cw, 1'($urandom), "");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule